// File: doc/BRIEF.md
# Serial Debug Bus Access Engine

This engine sits behind a serial debug physical layer and turns a stream of received bytes into accesses on a target's byte-wide data bus, on an internal 32-bit pointer register, and on a small internal file of control/status bytes. Each transaction opens with one command byte. The engine then collects any address bytes and any write-data bytes, issues one single-byte bus cycle per data byte, and sends read bytes back on a byte-wide transmit channel. Receive and transmit both use valid/ready handshakes. Bit framing, parity and clock recovery belong to the physical layer and are outside this block.

Command byte layout: bits [7:5] hold the opcode, and bit 4 must be zero. For direct commands, bits [3:2] give the address size minus one and bits [1:0] give the data size minus one. For pointer commands, bits [3:2] select the pointer mode. For control/status commands, bits [3:0] give the register index. Opcode values: 0 is direct load, 1 is direct store, 2 is pointer load, 3 is pointer store, 4 is control/status load and 5 is control/status store. Opcodes 6 and 7 are discarded. Pointer mode values: 0 is dereference, 1 is dereference with post-increment, 2 is the pointer register itself, and 3 is reserved. Multi-byte fields travel least-significant byte first.

The state machine has six states. S_IDLE waits for a command byte. S_ADDR collects address bytes. S_WDAT waits for a write-data byte. S_BWR holds a bus write until it is acknowledged. S_BRD holds a bus read until it is acknowledged. S_SEND presents one byte on the transmit channel. The transitions are:
- S_IDLE goes to S_ADDR on a direct command.
- S_IDLE goes to S_BRD on a pointer load in mode 0 or 1.
- S_IDLE goes to S_SEND on a pointer-register load or a control/status load.
- S_IDLE goes to S_WDAT on any pointer store or a control/status store.
- S_IDLE stays put on a discarded byte.
- S_ADDR goes to S_BRD or S_WDAT after the last address byte.
- S_WDAT goes to S_BWR for bus data. For pointer or control/status data it stays in S_WDAT until the last byte, then goes to S_IDLE.
- S_BWR goes to S_WDAT on acknowledge, or to S_IDLE if that was the last byte.
- S_BRD goes to S_SEND on acknowledge.
- S_SEND goes to S_BRD, stays in S_SEND, or goes to S_IDLE once the transmit byte is taken.

Top module: `sdb_engine`

## Requirements
- R1: A command byte with opcode 6 or 7, or with bit 4 set, is discarded. It causes no bus cycle and no transmit byte, and the next received byte is treated as a new command.
- R2: For direct commands, command bits [3:2] give the address byte count minus one and bits [1:0] give the data byte count minus one. Each count is 1 to 4.
- R3: A direct load or store receives all of its address bytes, least-significant first and zero-extended to 32 bits, before any bus cycle starts. Data byte k uses bus address = address + k.
- R4: Each data byte costs exactly one bus cycle. bus_rd or bus_wr stays high, with address and write data stable, until the cycle in which bus_ack is high. bus_rd and bus_wr are never high together.
- R5: rx_ready is low whenever a bus request or a transmit byte is pending.
- R6: Each byte that is read is presented on tx_data with tx_valid and held until tx_ready. A multi-byte read comes out least-significant byte first, and tx_valid follows in the cycle after a read acknowledge.
- R7: In pointer mode 0, the bus addresses are pointer + k and the pointer register is left unchanged.
- R8: In pointer mode 1, the pointer register is incremented by one after each acknowledged byte access.
- R9: In pointer mode 2, a load returns the pointer bytes least-significant first. A store writes the pointer bytes least-significant first and clears the bytes it does not write. Neither causes bus activity. Pointer mode 3 is discarded.
- R10: Control/status load and store move exactly one byte to or from the register selected by command bits [3:0], with no bus activity. Every register reads zero after reset.
- R11: During and after reset the engine is in S_IDLE: rx_ready high, tx_valid, bus_rd and bus_wr low, and the pointer register zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received byte valid |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Engine accepts a received byte |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Physical layer takes the transmit byte |
| bus_addr | output | 32 | Target bus byte address |
| bus_wdata | output | 8 | Target bus write data |
| bus_rd | output | 1 | Bus read request |
| bus_wr | output | 1 | Bus write request |
| bus_rdata | input | 8 | Bus read data, valid with bus_ack |
| bus_ack | input | 1 | One-cycle acknowledge of the current request |

## Verification
The assertions watch the handshake rules on every cycle. They check that rx_ready is held off while a request is pending, that read and write strobes never overlap, that requests and transmit bytes stay stable until they are acknowledged, and that tx_valid follows a read acknowledge. Address sequencing, byte ordering, pointer increment and clearing, control/status storage and the discarding of bad commands depend on the contents of whole transactions. Only the bench's directed scenarios can show those, by comparing bus logs, target memory and returned bytes.

// File: rtl/sdb_pkg.sv
package sdb_pkg;
    localparam int ADDR_W = 32;

    typedef enum logic [2:0] {
        OP_DLD = 3'd0, OP_DST = 3'd1, OP_PLD = 3'd2, OP_PST = 3'd3,
        OP_CLD = 3'd4, OP_CST = 3'd5, OP_RSV6 = 3'd6, OP_RSV7 = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        PM_DEREF = 2'd0, PM_INC = 2'd1, PM_REG = 2'd2, PM_RSV = 2'd3
    } pmode_e;

    typedef enum logic [1:0] {TG_BUS, TG_PTR, TG_CSR} tgt_e;

    typedef enum logic [2:0] {S_IDLE, S_ADDR, S_WDAT, S_BWR, S_BRD, S_SEND} state_e;

    typedef struct packed {
        op_e        op;
        logic [1:0] asize;
        logic [1:0] dsize;
        pmode_e     pmode;
        logic [3:0] csr_addr;
        logic       accept;
        logic       is_load;
    } cmd_t;
endpackage

// File: rtl/sdb_decode.sv
module sdb_decode
    import sdb_pkg::*;
(
    input  logic [7:0] cmd,
    output cmd_t       dec
);
    logic is_ptr;

    always_comb begin
        dec.op       = op_e'(cmd[7:5]);
        dec.asize    = cmd[3:2];
        dec.dsize    = cmd[1:0];
        dec.pmode    = pmode_e'(cmd[3:2]);
        dec.csr_addr = cmd[3:0];
        is_ptr       = (dec.op == OP_PLD) || (dec.op == OP_PST);
        dec.accept   = !cmd[4] && (cmd[7:5] <= 3'd5) && !(is_ptr && dec.pmode == PM_RSV);
        dec.is_load  = (dec.op == OP_DLD) || (dec.op == OP_PLD) || (dec.op == OP_CLD);
    end
endmodule

// File: rtl/sdb_csr_file.sv
module sdb_csr_file #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] idx,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    logic [7:0] regs [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[g] <= 8'h00;
            else if (we && idx == AW'(g))
                regs[g] <= wdata;
        end
    end

    assign rdata = regs[idx];
endmodule

// File: rtl/sdb_engine.sv
module sdb_engine
    import sdb_pkg::*;
#(
    parameter int CSR_DEPTH = 16,
    localparam int CSR_AW = $clog2(CSR_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    output logic              bus_rd,
    output logic              bus_wr,
    input  logic [7:0]        bus_rdata,
    input  logic              bus_ack
);
    state_e              state, nxt;
    tgt_e                tgt_q;
    cmd_t                dec;
    logic                load_q, postinc_q;
    logic [1:0]          asize_q, dsize_q, cnt_q;
    logic [ADDR_W-1:0]   addr_q, ptr_q;
    logic [7:0]          dbyte_q, csr_rdata;
    logic [CSR_AW-1:0]   csr_idx_q;
    logic                last, csr_we;

    sdb_decode u_dec (.cmd(rx_data), .dec(dec));

    sdb_csr_file #(.DEPTH(CSR_DEPTH)) u_csr (
        .clk(clk), .rst_n(rst_n), .we(csr_we), .idx(csr_idx_q),
        .wdata(rx_data), .rdata(csr_rdata)
    );

    assign last   = (cnt_q == dsize_q);
    assign csr_we = (state == S_WDAT) && rx_valid && (tgt_q == TG_CSR);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (rx_valid && dec.accept) begin
                unique case (dec.op)
                    OP_DLD, OP_DST: nxt = S_ADDR;
                    OP_PLD:         nxt = (dec.pmode == PM_REG) ? S_SEND : S_BRD;
                    OP_PST, OP_CST: nxt = S_WDAT;
                    OP_CLD:         nxt = S_SEND;
                    default:        nxt = S_IDLE;
                endcase
            end
            S_ADDR: if (rx_valid && cnt_q == asize_q)
                nxt = load_q ? S_BRD : S_WDAT;
            S_WDAT: if (rx_valid) begin
                if (tgt_q == TG_BUS) nxt = S_BWR;
                else if (last)       nxt = S_IDLE;
            end
            S_BWR:  if (bus_ack) nxt = last ? S_IDLE : S_WDAT;
            S_BRD:  if (bus_ack) nxt = S_SEND;
            S_SEND: if (tx_ready) begin
                if (last)                 nxt = S_IDLE;
                else if (tgt_q == TG_BUS) nxt = S_BRD;
            end
            default: nxt = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rx_ready  = (state == S_IDLE) || (state == S_ADDR) || (state == S_WDAT);
        bus_rd    = (state == S_BRD);
        bus_wr    = (state == S_BWR);
        tx_valid  = (state == S_SEND);
        bus_addr  = addr_q;
        bus_wdata = dbyte_q;
        unique case (tgt_q)
            TG_PTR:  tx_data = ptr_q[{cnt_q, 3'b000} +: 8];
            TG_CSR:  tx_data = csr_rdata;
            default: tx_data = dbyte_q;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q     <= TG_BUS;
            load_q    <= 1'b0;
            postinc_q <= 1'b0;
            asize_q   <= '0;
            dsize_q   <= '0;
            cnt_q     <= '0;
            addr_q    <= '0;
            ptr_q     <= '0;
            dbyte_q   <= '0;
            csr_idx_q <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (rx_valid && dec.accept) begin
                    cnt_q     <= '0;
                    asize_q   <= dec.asize;
                    load_q    <= dec.is_load;
                    csr_idx_q <= dec.csr_addr[CSR_AW-1:0];
                    postinc_q <= (dec.op == OP_PLD || dec.op == OP_PST) && dec.pmode == PM_INC;
                    dsize_q   <= (dec.op == OP_CLD || dec.op == OP_CST) ? 2'd0 : dec.dsize;
                    addr_q    <= (dec.op == OP_DLD || dec.op == OP_DST) ? '0 : ptr_q;
                    if (dec.op == OP_CLD || dec.op == OP_CST)
                        tgt_q <= TG_CSR;
                    else if ((dec.op == OP_PLD || dec.op == OP_PST) && dec.pmode == PM_REG)
                        tgt_q <= TG_PTR;
                    else
                        tgt_q <= TG_BUS;
                end
                S_ADDR: if (rx_valid) begin
                    addr_q[{cnt_q, 3'b000} +: 8] <= rx_data;
                    cnt_q <= (cnt_q == asize_q) ? 2'd0 : cnt_q + 2'd1;
                end
                S_WDAT: if (rx_valid) begin
                    if (tgt_q == TG_BUS) begin
                        dbyte_q <= rx_data;
                    end else begin
                        if (tgt_q == TG_PTR) begin
                            if (cnt_q == 2'd0) ptr_q <= {{(ADDR_W-8){1'b0}}, rx_data};
                            else               ptr_q[{cnt_q, 3'b000} +: 8] <= rx_data;
                        end
                        cnt_q <= cnt_q + 2'd1;
                    end
                end
                S_BWR: if (bus_ack) begin
                    addr_q <= addr_q + 1'b1;
                    if (postinc_q) ptr_q <= ptr_q + 1'b1;
                    cnt_q <= cnt_q + 2'd1;
                end
                S_BRD: if (bus_ack) begin
                    dbyte_q <= bus_rdata;
                    addr_q  <= addr_q + 1'b1;
                    if (postinc_q) ptr_q <= ptr_q + 1'b1;
                end
                S_SEND: if (tx_ready) cnt_q <= cnt_q + 2'd1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sdb_engine_chk.sv
module sdb_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        rx_ready,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic [7:0]  tx_data,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic        bus_ack,
    input logic [31:0] bus_addr,
    input logic [7:0]  bus_wdata
);
    assert_rx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr || tx_valid) |-> !rx_ready);

    assert_one_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_rd, bus_wr}));

    assert_rd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_ack) |=> (bus_rd && $stable(bus_addr)));

    assert_wr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_ack) |=> (bus_wr && $stable(bus_addr) && $stable(bus_wdata)));

    assert_tx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    assert_rd_to_tx_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_ack) |=> tx_valid);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_idle_R11: assert (rx_ready && !tx_valid && !bus_rd && !bus_wr);
        end
    end
endmodule

bind sdb_engine sdb_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rx_ready(rx_ready), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_ack(bus_ack), .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/sdb_engine_bench.sv
`timescale 1ns/100ps
module sdb_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        rx_ready;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;
    logic [31:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_rd, bus_wr;
    logic [7:0]  bus_rdata;
    logic        bus_ack;

    logic [7:0]  mem [256];
    logic [31:0] blog [64];
    int          bus_cnt;
    int          errors = 0;
    int          checks = 0;

    always #2.5 clk = ~clk;

    sdb_engine u_sdb_engine (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    // target bus model: acknowledge one cycle after the request is seen
    assign bus_rdata = mem[bus_addr[7:0]];
    always @(posedge clk) begin
        if (!rst_n) begin
            bus_ack <= 1'b0;
            bus_cnt <= 0;
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
        end else begin
            bus_ack <= (bus_rd || bus_wr) && !bus_ack;
            if ((bus_rd || bus_wr) && !bus_ack) begin
                blog[bus_cnt[5:0]] <= bus_addr;
                bus_cnt <= bus_cnt + 1;
            end
            if (bus_wr && !bus_ack) mem[bus_addr[7:0]] <= bus_wdata;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = b;
        while (!rx_ready) @(negedge clk);
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic recv(output logic [7:0] b);
        while (!tx_valid) @(negedge clk);
        b = tx_data;
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic read_ptr(output logic [31:0] p);
        logic [7:0] b;
        send(8'h4B);
        for (int k = 0; k < 4; k++) begin
            recv(b);
            p[8*k +: 8] = b;
        end
    endtask

    task automatic t_reset();
        chk("R11 rx_ready", {31'b0, rx_ready}, 32'd1);
        chk("R11 tx_valid", {31'b0, tx_valid}, 32'd0);
        chk("R11 bus strobes", {30'b0, bus_rd, bus_wr}, 32'd0);
    endtask

    task automatic t_direct_store();
        int b0 = bus_cnt;
        send(8'h26);            // direct store, 2 address bytes, 3 data bytes (R2)
        send(8'h10);
        send(8'h00);
        settle();
        chk("R3 no bus cycle before data", bus_cnt - b0, 0);
        send(8'hA1);
        send(8'hB2);
        send(8'hC3);
        settle();
        chk("R4 one cycle per byte", bus_cnt - b0, 3);
        chk("R3 byte0 addr", blog[b0[5:0]], 32'h10);
        chk("R3 byte2 addr", blog[(b0 + 2) & 63], 32'h12);
        chk("R2 mem 0x10", {24'b0, mem[8'h10]}, 32'hA1);
        chk("R2 mem 0x12", {24'b0, mem[8'h12]}, 32'hC3);
    endtask

    task automatic t_direct_load();
        logic [7:0] b;
        int b0 = bus_cnt;
        send(8'h01);            // direct load, 1 address byte, 2 data bytes
        send(8'h11);
        chk("R5 rx_ready held off during read", {31'b0, rx_ready}, 32'd0);
        chk("R4 read request raised", {31'b0, bus_rd}, 32'd1);
        recv(b); chk("R6 read byte0", {24'b0, b}, 32'hB2);
        recv(b); chk("R6 read byte1", {24'b0, b}, 32'hC3);
        chk("R3 load addr byte1", blog[(b0 + 1) & 63], 32'h12);
    endtask

    task automatic t_long_addr();
        logic [7:0] b;
        int b0 = bus_cnt;
        send(8'h0C);            // direct load, 4 address bytes, 1 data byte
        send(8'h30); send(8'h00); send(8'h00); send(8'h01);
        recv(b);
        chk("R6 long addr data", {24'b0, b}, 32'h6A);
        chk("R3 full 32-bit address", blog[b0[5:0]], 32'h0100_0030);
        chk("R2 single byte access", bus_cnt - b0, 1);
    endtask

    task automatic t_ptr_reg();
        logic [31:0] p;
        int b0 = bus_cnt;
        send(8'h6B); send(8'h78); send(8'h56); send(8'h34); send(8'h12);
        read_ptr(p);
        chk("R9 pointer write/read", p, 32'h1234_5678);
        send(8'h68); send(8'h20);   // 1-byte pointer store clears upper bytes
        read_ptr(p);
        chk("R9 upper pointer bytes cleared", p, 32'h20);
        chk("R9 no bus activity", bus_cnt - b0, 0);
    endtask

    task automatic t_ptr_inc();
        logic [31:0] p;
        send(8'h65); send(8'h55); send(8'h66);  // post-increment store, 2 bytes
        settle();
        chk("R8 mem 0x20", {24'b0, mem[8'h20]}, 32'h55);
        chk("R8 mem 0x21", {24'b0, mem[8'h21]}, 32'h66);
        read_ptr(p);
        chk("R8 pointer advanced", p, 32'h22);
    endtask

    task automatic t_ptr_deref();
        logic [7:0] b;
        logic [31:0] p;
        int b0;
        send(8'h68); send(8'h20);
        b0 = bus_cnt;
        send(8'h41);            // dereference load, 2 bytes
        recv(b); chk("R7 deref byte0", {24'b0, b}, 32'h55);
        recv(b); chk("R7 deref byte1", {24'b0, b}, 32'h66);
        chk("R7 deref addr byte1", blog[(b0 + 1) & 63], 32'h21);
        read_ptr(p);
        chk("R7 pointer unchanged", p, 32'h20);
    endtask

    task automatic t_csr();
        logic [7:0] b;
        int b0 = bus_cnt;
        send(8'h80); recv(b);
        chk("R10 reset value", {24'b0, b}, 32'h00);
        send(8'hA5); send(8'h5A);
        send(8'h85); recv(b);
        chk("R10 stored value", {24'b0, b}, 32'h5A);
        send(8'h86); recv(b);
        chk("R10 neighbour untouched", {24'b0, b}, 32'h00);
        chk("R10 no bus activity", bus_cnt - b0, 0);
    endtask

    task automatic t_discard();
        logic [7:0] b;
        int b0 = bus_cnt;
        send(8'hE0); settle();
        chk("R1 opcode 7 no tx", {31'b0, tx_valid}, 32'd0);
        send(8'h90); settle();
        chk("R1 bit4 set no tx", {31'b0, tx_valid}, 32'd0);
        send(8'h4C); settle();
        chk("R9 pointer mode 3 no tx", {31'b0, tx_valid}, 32'd0);
        chk("R1 no bus activity", bus_cnt - b0, 0);
        send(8'h85); recv(b);
        chk("R1 next byte is a command", {24'b0, b}, 32'h5A);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direct_store();
        t_direct_load();
        t_long_addr();
        t_ptr_reg();
        t_ptr_inc();
        t_ptr_deref();
        t_csr();
        t_discard();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule